// File: doc/BRIEF.md
# Random Linear Network Coding Encoder

This block turns a generation of up to eight stored source packets into one coded packet per start request, using arithmetic over GF(2^8). Source packets are loaded byte by byte into an internal buffer through a simple write port while the block is idle. Every byte of a packet is one field symbol. A start strobe with a generation size n then launches a coded packet.

For each coded packet the block draws n fresh 8-bit weights from an internal 16-bit LFSR and emits them first. It then emits one coded symbol per payload position. Each coded symbol is the field-weighted sum of the n source symbols at that position. The n field products are formed in parallel by single-cycle combinational multipliers and combined with XOR. Lanes beyond n are forced to zero. The output is a valid/ready stream with a last flag.

Top module: `rlnc_encoder`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_last` and `err` are all 0.
- R2: A start accepted while idle with 1 <= `gen_size` <= MAX_N makes `busy` and `out_valid` high from the next cycle. The stream carries exactly `gen_size` weight beats, then SYMS payload beats. `out_last` is high only on the final payload beat. The block returns to idle after that beat is accepted.
- R3: Weights come from a 16-bit Galois LFSR with seed 0xACE1, shifting right and XOR-ing in mask 0xB400 when the bit shifted out is 1. A weight beat carries the low byte of the state. Each accepted weight beat advances the state by 8 steps. The state carries over between packets and reloads only on reset.
- R4: Payload beat s (s counting up from 0) carries the XOR over j < n of w_j times P_j[s]. The product is taken in GF(2^8) with reduction polynomial 0x11D, and w_j is the j-th weight beat of the same packet.
- R5: Stored packets with index >= n have no effect on the payload.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and the stream position hold.
- R7: A start with `gen_size` of 0 or above MAX_N is ignored, and `err` goes to 1. `err` returns to 0 on the next accepted start.
- R8: A start asserted while `busy` is high is ignored. It changes neither the length of the current packet nor `err`.
- R9: A write while idle stores `wr_data` as symbol `wr_addr` of packet `wr_pkt`. A write while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Source buffer write strobe |
| wr_pkt | input | 3 | Source packet index for the write |
| wr_addr | input | 8 | Symbol position for the write |
| wr_data | input | 8 | Symbol value to store |
| start | input | 1 | Request one coded packet |
| gen_size | input | 4 | Generation size n sampled with `start` |
| out_valid | output | 1 | Stream beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 8 | Weight or coded symbol |
| out_last | output | 1 | Final payload beat of the packet |
| busy | output | 1 | A coded packet is in progress |
| err | output | 1 | Last start request had an illegal size |

## Verification
Three of the block's actions can collide with streaming: a buffer write, a start request and consumer back-pressure. The bench drives a new start during the weight phase and writes new bytes during the payload phase. One of those writes targets the last symbol of the packet being streamed, and the other a symbol used by the following packet.

The bench judges the collision at the outputs. The current packet must keep its length and its final symbol. The next packet's symbols must still match a model that never applied the writes. The `err` flag must stay low throughout. A cyclic pattern on `out_ready` stalls both phases, and every beat is compared with the independent field model.

// File: rtl/rlnc_encoder.sv
module rlnc_encoder #(
  parameter int          MAX_N = 8,
  parameter int          SYMS  = 256,
  parameter logic [15:0] SEED  = 16'hACE1,
  localparam int PW = $clog2(MAX_N),
  localparam int AW = $clog2(SYMS),
  localparam int NW = $clog2(MAX_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_pkt,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          start,
  input  logic [NW-1:0] gen_size,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          busy,
  output logic          err
);

  typedef enum logic [1:0] {IDLE, COEF, PAY} st_t;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [15:0] lfsr_adv8(input logic [15:0] s);
    logic [15:0] v;
    v = s;
    for (int i = 0; i < 8; i++) v = v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
    return v;
  endfunction

  st_t           st;
  logic [NW-1:0] n_q;
  logic [PW-1:0] k_q;
  logic [AW-1:0] sym_q;
  logic [15:0]   lfsr;
  logic [7:0]    coef [MAX_N];
  logic [7:0]    mem  [MAX_N][SYMS];
  logic [7:0]    prod [MAX_N];
  logic [7:0]    acc;

  wire fire    = out_valid && out_ready;
  wire bad_n   = (gen_size == '0) || (gen_size > NW'(MAX_N));
  wire k_last  = (NW'(k_q) == n_q - NW'(1));
  wire s_last  = (sym_q == AW'(SYMS - 1));

  assign out_valid = (st != IDLE);
  assign busy      = out_valid;
  assign out_last  = (st == PAY) && s_last;
  assign out_data  = (st == COEF) ? lfsr[7:0] : acc;

  always_ff @(posedge clk) begin
    if (wr_en && !busy) mem[wr_pkt][wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      n_q   <= '0;
      k_q   <= '0;
      sym_q <= '0;
      lfsr  <= SEED;
      err   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          if (bad_n) err <= 1'b1;
          else begin
            err <= 1'b0;
            n_q <= gen_size;
            k_q <= '0;
            st  <= COEF;
          end
        end
        COEF: if (fire) begin
          lfsr <= lfsr_adv8(lfsr);
          if (k_last) begin
            sym_q <= '0;
            st    <= PAY;
          end else k_q <= k_q + PW'(1);
        end
        PAY: if (fire) begin
          if (s_last) st <= IDLE;
          else sym_q <= sym_q + AW'(1);
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == COEF && fire) coef[k_q] <= lfsr[7:0];
  end

  for (genvar g = 0; g < MAX_N; g++) begin : g_lane
    logic lane_on;
    assign lane_on = (st == PAY) && (NW'(g) < n_q);
    assign prod[g] = lane_on ? gf_mul(coef[g], mem[g][sym_q]) : 8'h00;
  end

  always_comb begin
    acc = 8'h00;
    for (int j = 0; j < MAX_N; j++) acc ^= prod[j];
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));  // R6
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);  // R2
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);  // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(n_q) && !$rose(err));  // R8
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);  // R3
  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (n_q != '0) && (n_q <= NW'(MAX_N)));  // R2

endmodule

// File: tb/tb_rlnc_encoder.sv
module tb_rlnc_encoder;
  localparam int MAX_N = 8;
  localparam int SYMS  = 256;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, out_ready = 0;
  logic [2:0] wr_pkt = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [3:0] gen_size = 0;
  logic out_valid, out_last, busy, err;
  logic [7:0] out_data;

  rlnc_encoder #(.MAX_N(MAX_N), .SYMS(SYMS), .SEED(16'hACE1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pkt(wr_pkt), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .gen_size(gen_size), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .busy(busy), .err(err));

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0]  model [MAX_N][SYMS];
  logic [15:0] bl = 16'hACE1;
  logic [7:0]  capt [MAX_N];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // {ready mode, n, fill seed}
  localparam logic [12:0] VEC [0:5] = '{
    {1'b0, 4'd1, 8'h3A}, {1'b1, 4'd2, 8'h51}, {1'b0, 4'd3, 8'h07},
    {1'b1, 4'd5, 8'hC4}, {1'b0, 4'd8, 8'h9E}, {1'b1, 4'd8, 8'h00}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] aa;
    logic [7:0] bb, r;
    aa = {1'b0, a}; bb = b; r = 0;
    while (bb != 0) begin
      if (bb[0]) r ^= aa[7:0];
      aa = aa << 1;
      if (aa[8]) aa ^= 9'h11D;
      bb = bb >> 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] lstep(input logic [15:0] s);
    logic b;
    b = s[0];
    s = s >> 1;
    if (b) s ^= 16'hB400;
    return s;
  endfunction

  task automatic wr(input int p, input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_pkt = 3'(p); wr_addr = 8'(a); wr_data = d;
    model[p][a] = d;
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int p = 0; p < MAX_N; p++)
      for (int a = 0; a < SYMS; a++)
        wr(p, a, 8'(p * 37 + a * 13 + seed) ^ 8'(a >> 2));
    @(negedge clk);
    wr_en = 0;
  endtask

  // mode 0: always ready, 1: stalls, 2: stalls plus start/write injection
  task automatic run_pkt(input int n, input int mode);
    int beats = 0, it = 0;
    logic [7:0] prev = 0, exp;
    bit stalled = 0;
    @(negedge clk);
    start = 1; gen_size = 4'(n);
    @(negedge clk);
    start = 0;
    chk(busy && out_valid && !err, "R2 R7 start accepted", {busy, out_valid, err}, 3'b110);
    while (beats < n + SYMS && it < 4 * (n + SYMS) + 40) begin
      logic r;
      @(negedge clk);
      it++;
      if (mode == 2) begin
        if (it == 3) begin start = 1; gen_size = 4'd3; end
        if (it == 4) start = 0;
        if (it == n + 6) begin wr_en = 1; wr_pkt = 0; wr_addr = 8'(SYMS - 1); wr_data = ~model[0][SYMS-1]; end
        if (it == n + 7) begin wr_en = 1; wr_pkt = 1; wr_addr = 0; wr_data = ~model[1][0]; end
        if (it == n + 8) wr_en = 0;
      end
      if (stalled) chk(out_valid && out_data == prev, "R6 hold under stall", out_data, prev);
      r = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      out_ready = r;
      stalled = out_valid && !r;
      prev = out_data;
      if (out_valid && r) begin
        if (beats < n) begin
          exp = bl[7:0];
          chk(out_data == exp, "R3 weight", out_data, exp);
          capt[beats] = out_data;
          for (int i = 0; i < 8; i++) bl = lstep(bl);
        end else begin
          int s = beats - n;
          exp = 0;
          for (int j = 0; j < n; j++) exp ^= fmul(capt[j], model[j][s]);
          chk(out_data == exp, $sformatf("R4 R5 R9 symbol %0d n=%0d", s, n), out_data, exp);
        end
        chk(out_last == (beats == n + SYMS - 1), "R2 last flag", out_last, beats == n + SYMS - 1);
        beats++;
      end
    end
    @(negedge clk);
    out_ready = 0;
    chk(beats == n + SYMS, "R2 R8 beat count", beats, n + SYMS);
    chk(!busy && !out_valid && !err, "R2 R8 idle after packet", {busy, out_valid, err}, 0);
  endtask

  task automatic bad_start(input int n);
    @(negedge clk);
    start = 1; gen_size = 4'(n);
    @(negedge clk);
    start = 0;
    chk(err && !busy && !out_valid, $sformatf("R7 illegal size %0d", n), {err, busy, out_valid}, 3'b100);
  endtask

  initial begin
    #1800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !out_last && !err, "R1 reset state", {busy, out_valid, out_last, err}, 0);
    rst_n = 1;
    for (int v = 0; v < 6; v++) begin
      fill(VEC[v][7:0]);
      run_pkt(int'(VEC[v][11:8]), int'(VEC[v][12]));
    end
    run_pkt(4, 2);   // R8 R9 collisions, model left untouched
    run_pkt(4, 0);
    bad_start(0);
    bad_start(9);
    bad_start(15);
    run_pkt(2, 1);   // R7 clears err
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!busy && !out_valid && !out_last && !err, "R1 reset again", {busy, out_valid, out_last, err}, 0);
    rst_n = 1;
    bl = 16'hACE1;   // R3 reseed
    run_pkt(3, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule